// File: doc/BRIEF.md
# Configurable Group Concentration Array

A rectangular mesh of bit-serial crosspoint cells that gathers cells arriving on its rows onto output links on its columns. Each row takes one serial cell stream from the west. Each column starts at the top with a locally made filler stream and leaves at the bottom as one output link. Adjacent columns are bundled into output groups. A cell addressed to a group takes the first column of that group where it outranks the current occupant. The cell it pushes out carries on eastward and competes for the next column. A cell that finds no column leaves on the east edge of its row.

Three framing strobes mark the cell layout: a frame-start pulse, an address window and a priority window. They enter at the top-left cell and every cell passes them one clock on, to the east and to the south, so each cell's frame begins one cycle after its west and north neighbours. Row r's west stream is therefore applied r cycles after row 0's. Two mode bits set how many columns make up a group. A third bit picks unicast operation or multicast operation. In unicast the top of each column is fed with an idle cell. In multicast it is held high.

Top module: `grp_concentrator`

## Requirements
- R1: A cell is a serial word sent MSB first: a frame-start slot whose bit is ignored, 3 address bits, 3 priority bits, then 4 payload bits (bit index j = 0..9 after the slot). If the frame-start pulse enters at cycle T0 and row r drives its bit j in cycle T0+1+j+r, the bit leaves south link c in cycle T0+1+j+ROWS+c, or leaves east row r in cycle T0+1+j+r+COLS.
- R2: The strobe triple {frame-start, address, priority} reappears on the east strobe outputs exactly COLS cycles after it is applied at the inputs. At most one of the three is high in any cycle.
- R3: A cell swaps its paths (west cell to south, north cell to east) only when both addresses are equal and the west priority is strictly greater as an unsigned number. With equal priority or unequal address it passes west to east and north to south.
- R4: The frame-start pulse returns every cell to the pass-through state before its address window, so a swap in one frame has no effect on the next.
- R5: Group size is (COLS/8) << mode_grp columns, which gives 8, 4, 2 or 1 groups for mode_grp = 00, 01, 10, 11. Column c belongs to group c / size.
- R6: In unicast (mode_mcast = 0) the north input of top-row column c carries an idle cell with address equal to the column's group number, priority 0 and payload 0.
- R7: In multicast (mode_mcast = 1) the top-row north inputs are held at 1 for the whole frame.
- R8: Cells compete in row order. A later cell with higher priority displaces an earlier one, and the displaced cell goes on east to claim the next free column of its group.
- R9: A cell whose address names no group under the current mode claims no column and leaves the east edge unchanged.
- R10: While rst_n is low at a clock edge, all south and east outputs are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_grp | input | 2 | Group size select, sampled by each column at its frame start |
| mode_mcast | input | 1 | 1 = multicast, 0 = unicast, sampled with mode_grp |
| init_i | input | 1 | Frame-start strobe, one cycle per frame |
| addr_stb_i | input | 1 | High during the 3 address bits |
| prio_stb_i | input | 1 | High during the 3 priority bits |
| west_i | input | ROWS | Serial cell input per row, row r skewed by r cycles |
| south_o | output | COLS | Serial output link per column |
| east_o | output | ROWS | Serial overflow output per row |
| init_east_o | output | 1 | Frame-start strobe leaving the east edge |
| addr_east_o | output | 1 | Address strobe leaving the east edge, marks the address bits for a cascaded array |
| prio_east_o | output | 1 | Priority strobe leaving the east edge |

## Verification
All timing follows from the frame-start cycle T0. A south bit is due ROWS+c+1+j cycles after T0 and an east bit COLS+r+1+j cycles after T0. The east strobe copies are due COLS cycles after the input strobes. For every frame, the driver works out the cell-level result from the group rules and queues each expected bit with the exact cycle it is due. The monitor samples on the falling edge of that cycle only, so no result is read before its last register has updated. Frames follow each other with no gap, which means a stale swap or a wrong skew would show up in a later frame's bits.

// File: rtl/grp_conc_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the group concentration array.
// Assumes: group address field is 3 bits wide (at most 8 groups).
package grp_conc_pkg;
    localparam int GRP_ADDR_W = 3;

    // Framing strobes travelling with the cells through the mesh.
    typedef struct packed {
        logic init;   // frame start, one cycle before the address window
        logic addr;   // address bits window
        logic prio;   // priority bits window
    } frame_strb_t;
endpackage

// File: rtl/xpt_cell.sv
`timescale 1ns/1ps
// One bit-serial crosspoint of the concentration mesh.
// Passes west->east and north->south until, inside the priority window,
// it sees matching addresses and the west bit is 1 where the north bit is 0
// at the first differing priority bit. From that bit on, it swaps paths.
// Bits before that point are identical on both inputs, so swapping late
// never corrupts a cell. Every output is registered (one hop = one clock).
// Assumes the strobes arrive aligned with the data bits they describe.
module xpt_cell
    import grp_conc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  frame_strb_t strb_i,
    input  logic        w_i,
    input  logic        n_i,
    output logic        e_o,
    output logic        s_o,
    output frame_strb_t strb_o
);
    logic match_q;   // addresses equal so far in this frame
    logic eq_q;      // priorities equal so far in this frame
    logic swap_q;    // swapped state held for the rest of the frame
    logic diff;
    logic win_now;
    logic swap_now;

    // Decide the path for the bit currently at the inputs.
    always_comb begin
        diff     = w_i ^ n_i;
        win_now  = strb_i.prio && match_q && eq_q && diff && w_i;
        swap_now = !strb_i.init && (swap_q || win_now);
    end

    // Register the routed bits, forward the strobes and track compare state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb_o  <= '0;
            e_o     <= 1'b0;
            s_o     <= 1'b0;
            match_q <= 1'b1;
            eq_q    <= 1'b1;
            swap_q  <= 1'b0;
        end else begin
            strb_o <= strb_i;
            e_o    <= swap_now ? n_i : w_i;
            s_o    <= swap_now ? w_i : n_i;
            if (strb_i.init) begin
                match_q <= 1'b1;
                eq_q    <= 1'b1;
                swap_q  <= 1'b0;
            end else begin
                if (strb_i.addr && diff)
                    match_q <= 1'b0;
                if (strb_i.prio && match_q && eq_q && diff)
                    eq_q <= 1'b0;
                swap_q <= swap_now;
            end
        end
    end
endmodule

// File: rtl/col_idle_src.sv
`timescale 1ns/1ps
// Filler stream for the north edge of one column.
// Unicast: idle cell = group number in the address field, zeros elsewhere.
// Multicast: constant 1.
// Mode is captured at the column's own frame start, so a mode change only
// has to be stable from the array's frame start until the last column's.
// Assumes the strobes are the ones seen by the top cell of this column.
module col_idle_src
    import grp_conc_pkg::*;
#(
    parameter int COL_IDX  = 0,
    parameter int LOG_BASE = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  frame_strb_t strb_i,
    input  logic [1:0]  mode_grp,
    input  logic        mode_mcast,
    output logic        north_o
);
    logic [GRP_ADDR_W-1:0] gid_w;
    logic [GRP_ADDR_W-1:0] sh_q;
    logic                  mc_q;

    // Group number of this column under the requested grouping.
    always_comb gid_w = GRP_ADDR_W'(COL_IDX >> (LOG_BASE + int'(mode_grp)));

    // Load at frame start, shift out MSB first through the address window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
            mc_q <= 1'b0;
        end else if (strb_i.init) begin
            sh_q <= gid_w;
            mc_q <= mode_mcast;
        end else if (strb_i.addr) begin
            sh_q <= {sh_q[GRP_ADDR_W-2:0], 1'b0};
        end
    end

    // Serial filler bit: address bits in the window, zeros after, or all ones.
    always_comb north_o = mc_q | (strb_i.addr & sh_q[GRP_ADDR_W-1]);
endmodule

// File: rtl/grp_concentrator.sv
`timescale 1ns/1ps
// Group concentration array: ROWS x COLS mesh of xpt_cell.
// West streams enter per row, column links leave from the bottom row,
// overflow leaves from the east column. Strobes enter at cell (0,0) and
// ripple one hop per clock, so cell (r,c) is r+c cycles behind the inputs.
// Assumes COLS is a power of two and at least 8; ROWS at least 1.
module grp_concentrator
    import grp_conc_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode_grp,
    input  logic            mode_mcast,
    input  logic            init_i,
    input  logic            addr_stb_i,
    input  logic            prio_stb_i,
    input  logic [ROWS-1:0] west_i,
    output logic [COLS-1:0] south_o,
    output logic [ROWS-1:0] east_o,
    output logic            init_east_o,
    output logic            addr_east_o,
    output logic            prio_east_o
);
    localparam int LOG_BASE = $clog2(COLS / 8);

    frame_strb_t     strb_in0;
    frame_strb_t     strb_a [ROWS][COLS];
    logic            e_a    [ROWS][COLS];
    logic            s_a    [ROWS][COLS];
    logic [COLS-1:0] north_top;

    // Strobe triple as applied at the top-left corner.
    assign strb_in0 = {init_i, addr_stb_i, prio_stb_i};

    // North filler sources, one per column, aligned with the top-row cell.
    for (genvar c = 0; c < COLS; c++) begin : g_src
        frame_strb_t s_col;
        if (c == 0) begin : g_first
            assign s_col = strb_in0;
        end else begin : g_next
            assign s_col = strb_a[0][c-1];
        end
        col_idle_src #(
            .COL_IDX  (c),
            .LOG_BASE (LOG_BASE)
        ) u_src (
            .clk        (clk),
            .rst_n      (rst_n),
            .strb_i     (s_col),
            .mode_grp   (mode_grp),
            .mode_mcast (mode_mcast),
            .north_o    (north_top[c])
        );
    end

    // Mesh of crosspoints with neighbour-only wiring.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            frame_strb_t s_in;
            logic        w_in;
            logic        n_in;
            if (r == 0 && c == 0) begin : g_s_corner
                assign s_in = strb_in0;
            end else if (c == 0) begin : g_s_north
                assign s_in = strb_a[r-1][0];
            end else begin : g_s_west
                assign s_in = strb_a[r][c-1];
            end
            if (c == 0) begin : g_w_edge
                assign w_in = west_i[r];
            end else begin : g_w_mesh
                assign w_in = e_a[r][c-1];
            end
            if (r == 0) begin : g_n_edge
                assign n_in = north_top[c];
            end else begin : g_n_mesh
                assign n_in = s_a[r-1][c];
            end
            xpt_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .strb_i (s_in),
                .w_i    (w_in),
                .n_i    (n_in),
                .e_o    (e_a[r][c]),
                .s_o    (s_a[r][c]),
                .strb_o (strb_a[r][c])
            );
        end
    end

    // Edge outputs.
    for (genvar c = 0; c < COLS; c++) begin : g_south
        assign south_o[c] = s_a[ROWS-1][c];
    end
    for (genvar r = 0; r < ROWS; r++) begin : g_east
        assign east_o[r] = e_a[r][COLS-1];
    end
    assign {init_east_o, addr_east_o, prio_east_o} = strb_a[0][COLS-1];
endmodule

// File: rtl/grp_concentrator_chk.sv
`timescale 1ns/1ps
// Property checker for grp_concentrator, bound to every instance.
// Keeps its own strobe delay line and column-0 mode capture.
module grp_concentrator_chk #(
    parameter int ROWS = 4,
    parameter int COLS = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            init_i,
    input logic            addr_stb_i,
    input logic            prio_stb_i,
    input logic            mode_mcast,
    input logic            init_east_o,
    input logic            addr_east_o,
    input logic            prio_east_o,
    input logic [COLS-1:0] south_o,
    input logic [ROWS-1:0] east_o,
    input logic [COLS-1:0] north_top
);
    logic [2:0] dl [COLS];
    logic       mc0;
    logic       was_rst;

    // Reference delay line for the strobe wavefront.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < COLS; k++) dl[k] <= '0;
        end else begin
            dl[0] <= {init_i, addr_stb_i, prio_stb_i};
            for (int k = 1; k < COLS; k++) dl[k] <= dl[k-1];
        end
    end

    // Mode seen by column 0 at its frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) mc0 <= 1'b0;
        else if (init_i) mc0 <= mode_mcast;
    end

    // Reset seen at the previous edge.
    always_ff @(posedge clk) was_rst <= !rst_n;

    assert_strobe_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        {init_east_o, addr_east_o, prio_east_o} == dl[COLS-1]);

    assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({init_east_o, addr_east_o, prio_east_o}));

    assert_mcast_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (init_i && mode_mcast) |=> north_top[0]);

    assert_idle_col0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr_stb_i || prio_stb_i) && !mc0) |-> !north_top[0]);

    // Outputs cleared by a reset at the previous edge.
    always @(posedge clk) begin
        if (was_rst === 1'b1) begin
            assert_reset_clear_R10: assert (south_o == '0 && east_o == '0)
                else $error("outputs not cleared by reset");
        end
    end
endmodule

bind grp_concentrator grp_concentrator_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (.*);

// File: tb/tb_grp_concentrator.sv
`timescale 1ns/1ps
module tb_grp_concentrator;
    localparam int ROWS = 4;
    localparam int COLS = 8;
    localparam int AW   = 3;
    localparam int PW   = 3;
    localparam int DW   = 4;
    localparam int WW   = AW + PW + DW;
    localparam int FR   = WW + 1;
    localparam int NF   = 9;
    localparam int BASE = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      mode_grp = '0;
    logic            mode_mcast = 1'b0;
    logic            init_i = 1'b0;
    logic            addr_stb_i = 1'b0;
    logic            prio_stb_i = 1'b0;
    logic [ROWS-1:0] west_i = '0;
    logic [COLS-1:0] south_o;
    logic [ROWS-1:0] east_o;
    logic            init_east_o, addr_east_o, prio_east_o;

    grp_concentrator #(.ROWS(ROWS), .COLS(COLS)) dut (.*);

    always #10 clk = ~clk;   // 50 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    due;
        int    kind;   // 0 south, 1 east, 2 addr strobe east, 3 init strobe east
        int    idx;
        logic  val;
        string req;
    } item_t;

    item_t          sb[$];
    int             n_chk = 0;
    int             n_bad = 0;
    logic [WW-1:0]  fr_cell [NF][ROWS];
    logic [1:0]     fr_grp  [NF];
    logic           fr_mc   [NF];

    task automatic check(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] mk(int a, int p, int d);
        return {AW'(a), PW'(p), DW'(d)};
    endfunction

    // Driver task: records the frame and queues the cell-level expected bits.
    task automatic plan_frame(int f, logic [1:0] g, logic mc, string tag,
                              logic [WW-1:0] c0, logic [WW-1:0] c1,
                              logic [WW-1:0] c2, logic [WW-1:0] c3);
        logic [WW-1:0] col [COLS];
        logic [WW-1:0] cur;
        logic [WW-1:0] tmp;
        logic [WW-1:0] eout [ROWS];
        int            t0;
        item_t         it;
        fr_cell[f][0] = c0; fr_cell[f][1] = c1; fr_cell[f][2] = c2; fr_cell[f][3] = c3;
        fr_grp[f] = g;
        fr_mc[f]  = mc;
        t0 = BASE + f * FR;
        for (int c = 0; c < COLS; c++) begin
            if (mc) col[c] = '1;
            else    col[c] = {AW'(c / ((COLS / 8) << g)), PW'(0), DW'(0)};
        end
        for (int r = 0; r < ROWS; r++) begin
            cur = fr_cell[f][r];
            for (int c = 0; c < COLS; c++) begin
                if (cur[WW-1 -: AW] == col[c][WW-1 -: AW] &&
                    cur[WW-AW-1 -: PW] > col[c][WW-AW-1 -: PW]) begin
                    tmp = col[c]; col[c] = cur; cur = tmp;
                end
            end
            eout[r] = cur;
        end
        for (int j = 0; j < WW; j++) begin
            for (int c = 0; c < COLS; c++) begin
                it = '{due: t0 + 1 + j + ROWS + c, kind: 0, idx: c, val: col[c][WW-1-j], req: tag};
                sb.push_back(it);
            end
            for (int r = 0; r < ROWS; r++) begin
                it = '{due: t0 + 1 + j + r + COLS, kind: 1, idx: r, val: eout[r][WW-1-j], req: tag};
                sb.push_back(it);
            end
        end
        for (int j = 0; j <= AW; j++) begin
            it = '{due: t0 + 1 + j + COLS, kind: 2, idx: 0, val: (j < AW), req: "R2"};
            sb.push_back(it);
        end
        it = '{due: t0 + COLS, kind: 3, idx: 0, val: 1'b1, req: "R2"};
        sb.push_back(it);
    endtask

    // Stimulus: strobes, mode and skewed west streams from the recorded frames.
    always @(negedge clk) begin
        int rel;
        int m;
        rel = cyc - BASE;
        init_i = 1'b0; addr_stb_i = 1'b0; prio_stb_i = 1'b0;
        if (rel >= 0 && rel / FR < NF) begin
            init_i     = (rel % FR == 0);
            addr_stb_i = (rel % FR >= 1) && (rel % FR <= AW);
            prio_stb_i = (rel % FR > AW) && (rel % FR <= AW + PW);
            if (rel % FR == 0) begin
                mode_grp   = fr_grp[rel / FR];
                mode_mcast = fr_mc[rel / FR];
            end
        end
        for (int r = 0; r < ROWS; r++) begin
            m = rel - 1 - r;
            if (m >= 0 && m / FR < NF && m % FR <= FR - 2)
                west_i[r] = fr_cell[m / FR][r][WW-1-(m % FR)];
            else
                west_i[r] = 1'b0;
        end
    end

    // Monitor: pops every item due in this cycle and compares.
    always @(negedge clk) begin
        logic act;
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                case (sb[i].kind)
                    0:       act = south_o[sb[i].idx];
                    1:       act = east_o[sb[i].idx];
                    2:       act = addr_east_o;
                    default: act = init_east_o;
                endcase
                check(sb[i].req, $sformatf("kind%0d idx%0d", sb[i].kind, sb[i].idx), act, sb[i].val);
                sb.delete(i);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        plan_frame(0, 2'b01, 1'b0, "R6", '0, '0, '0, '0);
        plan_frame(1, 2'b00, 1'b0, "R3", mk(3,5,10), mk(3,5,11), mk(3,6,12), '0);
        plan_frame(2, 2'b00, 1'b0, "R4", '0, '0, '0, '0);
        plan_frame(3, 2'b10, 1'b0, "R5", mk(1,1,1), mk(1,2,2), mk(1,3,3), mk(1,4,4));
        plan_frame(4, 2'b11, 1'b0, "R8", mk(0,2,5), mk(0,7,6), mk(0,1,7), mk(0,7,8));
        plan_frame(5, 2'b10, 1'b0, "R9", mk(2,7,9), mk(5,3,10), mk(0,4,11), '0);
        plan_frame(6, 2'b00, 1'b1, "R7", mk(7,7,15), mk(7,6,3), mk(2,1,12), '0);
        plan_frame(7, 2'b01, 1'b0, "R5", mk(3,4,1), mk(3,6,2), mk(3,5,3), mk(2,1,4));
        plan_frame(8, 2'b00, 1'b0, "R1", mk(0,1,13), mk(7,2,14), mk(4,3,1), mk(1,5,2));
        wait (cyc == 4);
        @(negedge clk);
        for (int c = 0; c < COLS; c++) check("R10", "south after reset", south_o[c], 1'b0);
        for (int r = 0; r < ROWS; r++) check("R10", "east after reset", east_o[r], 1'b0);
        check("R10", "addr strobe after reset", addr_east_o, 1'b0);
        rst_n = 1'b1;
        wait (cyc == BASE + NF * FR + ROWS + COLS + WW + 4);
        @(negedge clk);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R1 items never sampled: actual %0d expected 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule